// File: doc/BRIEF.md
# Time-over-threshold hit sparsifier

This block is the digital back end of a multi-channel strip readout chip. Each strip delivers two comparator bits. The low comparator sits near a quarter of a minimum-ionising signal and acts as the readout threshold. The high comparator sits at the higher operating-point threshold. The block runs on one fast clock. An internal divider makes a sampling strobe every eight fast cycles, and each strobe stands for one 400 ns sampling period. A free-running event-time counter advances on every strobe and supplies the timestamp of every transition.

A low-comparator rising edge opens a window on that channel. The window stays open until the low bit is seen clear or until the window has lasted a programmable maximum time-over-threshold. When the window closes, the channel's record is kept only if the high comparator fired on the channel itself or on an adjacent strip during the window. Adjacent strips count so that the charge centroid can still be formed. A kept record becomes two FIFO words: the leading transition and the trailing transition. Records are drained lowest channel first. The FIFO output is serialised 8:1 into narrow slices, one slice per fast cycle, so eight slices fill one sampling period.

Top module: `tot_sparsifier`

## Requirements
- R1: The event time is zero for the first sample after reset release and rises by one per sample. A sample is taken every 8 clock cycles, the first on the 8th rising edge after reset release. The count wraps at TW bits.
- R2: A window opens on a sample where the low bit is 1 and the previous sample's low bit was 0. The leading word carries that sample's time. The trailing word carries the time of the first later sample with the low bit at 0, with the timeout bit at 0.
- R3: A closed window produces words only if the channel's own high bit, or the high bit of an adjacent channel, was sampled 1 on some sample from the opening sample through the closing sample. Otherwise the window produces no word.
- R4: Adjacency does not wrap. Channel 0 has only channel 1 as a neighbour, and the last channel has only the one below it.
- R5: The window is force-closed on a sample where (sample time − leading time) mod 2^TW ≥ max_tot while low is still 1. Its trailing word carries that sample's time and has the timeout bit set to 1. The channel does not reopen until its low bit has been seen at 0 and then at 1.
- R6: Word layout, from the LSB: bits [TW-1:0] hold the time, bit TW is the timeout flag, bit TW+1 is 1 for trailing and 0 for leading, and bits [TW+2 +: CW] hold the channel number. A channel's leading word is pushed immediately followed by its trailing word. When several channels are waiting, they are drained lowest channel number first.
- R7: Each word is zero-padded to 8·SW bits and sent as 8 consecutive slices of SW bits, least significant slice first. out_valid is high on each slice, and out_first is high on slice 0 only.
- R8: A word that arrives while the FIFO is full is dropped and sets overflow. Overflow stays at 1 until an ovf_clr pulse clears it.
- R9: After reset, out_valid and overflow are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (one output slot per cycle) |
| rst | input | 1 | Synchronous active-high reset |
| lo_cmp | input | NCH | Low-threshold comparator bits, one per channel |
| hi_cmp | input | NCH | High-threshold comparator bits, one per channel |
| max_tot | input | TW | Longest window length, in samples, before a forced close |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | A slice is present on out_data |
| out_first | output | 1 | Marks slice 0 of a word |
| out_data | output | SW | Serialised word slice |
| overflow | output | 1 | Sticky flag: a word was dropped |

## Verification
A stimulus table feeds several patterns to the block. In the first, a three-strip cluster has its high hit only in the middle strip, so own-channel acceptance is told apart from neighbour acceptance. In the second, a lone low pulse has no high hit, so discarding is exercised. In the third, a pulse on the top strip has a partner pulse on channel 0, which would be kept only if adjacency wrapped. The table also holds a long pulse that must time out without reopening, and a later pulse on the same channel that shows the channel rearms. A directed burst that fires every channel at once fills the FIFO. It separates drop-and-flag from silent loss and confirms that the lowest channel drains first.

// File: rtl/tot_pkg.sv
package tot_pkg;
  localparam int SLOTS = 8;

  function automatic int slice_width(input int word_w);
    return (word_w + SLOTS - 1) / SLOTS;
  endfunction
endpackage

// File: rtl/tot_chan_track.sv
module tot_chan_track #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          lo,
  input  logic          hi,
  input  logic          nbr_hi,
  input  logic [TW-1:0] evt,
  input  logic [TW-1:0] max_tot,
  input  logic          clr,
  output logic          ready,
  output logic [TW-1:0] t_lead,
  output logic [TW-1:0] t_trail,
  output logic          tmo
);
  logic          lo_prev, open_q, keep_q, hit;
  logic [TW-1:0] age;

  always_comb begin
    hit = hi | nbr_hi;
    age = evt - t_lead;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_prev <= 1'b0;
      open_q  <= 1'b0;
      keep_q  <= 1'b0;
      ready   <= 1'b0;
      t_lead  <= '0;
      t_trail <= '0;
      tmo     <= 1'b0;
    end else begin
      if (clr) ready <= 1'b0;
      if (tick) begin
        lo_prev <= lo;
        if (open_q) begin
          if (!lo || age >= max_tot) begin
            open_q  <= 1'b0;
            t_trail <= evt;
            tmo     <= lo;
            ready   <= keep_q | hit;
          end else begin
            keep_q <= keep_q | hit;
          end
        end else if (!ready && lo && !lo_prev) begin
          open_q <= 1'b1;
          t_lead <= evt;
          keep_q <= hit;
        end
      end
    end
  end

  // A waiting record is only released by the drain logic (R6)
  p_ready_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ready && !clr) |=> ready);
endmodule

// File: rtl/tot_word_fifo.sv
module tot_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         rd_en,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;

  always_comb begin
    empty = (wptr == rptr);
    full  = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr[AW-1:0]] <= wdata;
    if (rd_en) rdata <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
    end
  end

  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
  p_no_push_full_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
endmodule

// File: rtl/tot_slicer.sv
module tot_slicer #(
  parameter int W     = 32,
  parameter int SW    = 4,
  parameter int SLOTS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          empty,
  input  logic [W-1:0]  rdata,
  output logic          rd_en,
  output logic          out_valid,
  output logic          out_first,
  output logic [SW-1:0] out_data
);
  localparam int PW  = SW * SLOTS;
  localparam int SLW = $clog2(SLOTS);

  logic          wait_q, active_q;
  logic [SLW-1:0] slot;
  logic [PW-1:0]  sh;

  always_comb
    rd_en = !empty && !wait_q && (!active_q || slot == SLW'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_q    <= 1'b0;
      active_q  <= 1'b0;
      slot      <= '0;
      sh        <= '0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_data  <= '0;
    end else begin
      wait_q    <= rd_en;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      if (wait_q) begin
        sh       <= PW'(rdata);
        active_q <= 1'b1;
        slot     <= '0;
      end else if (active_q) begin
        out_valid <= 1'b1;
        out_first <= (slot == '0);
        out_data  <= sh[SW-1:0];
        sh        <= sh >> SW;
        slot      <= slot + 1'b1;
        if (slot == SLW'(SLOTS - 1)) active_q <= 1'b0;
      end
    end
  end

  // slice 0 is always followed by slice 1 (R7)
  p_frame_cont_r7: assert property (@(posedge clk) disable iff (rst)
    out_first |=> (out_valid && !out_first));
  p_first_valid_r7: assert property (@(posedge clk) disable iff (rst)
    out_first |-> out_valid);
endmodule

// File: rtl/tot_sparsifier.sv
module tot_sparsifier
  import tot_pkg::*;
#(
  parameter int NCH        = 128,
  parameter int TW         = 16,
  parameter int FIFO_DEPTH = 64,
  localparam int CW        = $clog2(NCH),
  localparam int WORD_W    = CW + 2 + TW,
  localparam int SW        = slice_width(WORD_W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] lo_cmp,
  input  logic [NCH-1:0] hi_cmp,
  input  logic [TW-1:0]  max_tot,
  input  logic           ovf_clr,
  output logic           out_valid,
  output logic           out_first,
  output logic [SW-1:0]  out_data,
  output logic           overflow
);
  localparam int DW = $clog2(SLOTS);

  logic [DW-1:0]     div;
  logic              tick;
  logic [TW-1:0]     evt;
  logic [NCH-1:0]    nbr_hi, ready_v, clr_v, tmo_v;
  logic [TW-1:0]     lead_a  [NCH];
  logic [TW-1:0]     trail_a [NCH];
  logic [CW-1:0]     enc, cur;
  logic              any, busy;
  logic              push_v, fifo_full, fifo_empty, rd_en;
  logic [WORD_W-1:0] push_word, rdata;

  always_comb tick = (div == DW'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div <= '0;
      evt <= '0;
    end else begin
      div <= div + 1'b1;
      if (tick) evt <= evt + 1'b1;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    if (i == 0) begin : g_lo_edge
      assign nbr_hi[i] = hi_cmp[i+1];
    end else if (i == NCH - 1) begin : g_hi_edge
      assign nbr_hi[i] = hi_cmp[i-1];
    end else begin : g_mid
      assign nbr_hi[i] = hi_cmp[i-1] | hi_cmp[i+1];
    end
    assign clr_v[i] = busy && (cur == CW'(i));

    tot_chan_track #(.TW(TW)) trk_i (
      .clk(clk), .rst(rst), .tick(tick),
      .lo(lo_cmp[i]), .hi(hi_cmp[i]), .nbr_hi(nbr_hi[i]),
      .evt(evt), .max_tot(max_tot), .clr(clr_v[i]),
      .ready(ready_v[i]), .t_lead(lead_a[i]), .t_trail(trail_a[i]),
      .tmo(tmo_v[i])
    );
  end

  always_comb begin
    any = |ready_v;
    enc = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (ready_v[i]) enc = CW'(i);
  end

  always_comb begin
    push_v    = 1'b0;
    push_word = '0;
    if (busy) begin
      push_v    = 1'b1;
      push_word = {cur, 1'b1, tmo_v[cur], trail_a[cur]};
    end else if (any) begin
      push_v    = 1'b1;
      push_word = {enc, 1'b0, 1'b0, lead_a[enc]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cur      <= '0;
      overflow <= 1'b0;
    end else begin
      if (busy) begin
        busy <= 1'b0;
      end else if (any) begin
        busy <= 1'b1;
        cur  <= enc;
      end
      if (push_v && fifo_full) overflow <= 1'b1;
      else if (ovf_clr)        overflow <= 1'b0;
    end
  end

  tot_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst(rst), .wr_en(push_v && !fifo_full), .wdata(push_word),
    .rd_en(rd_en), .rdata(rdata), .full(fifo_full), .empty(fifo_empty)
  );

  tot_slicer #(.W(WORD_W), .SW(SW), .SLOTS(SLOTS)) slicer_i (
    .clk(clk), .rst(rst), .empty(fifo_empty), .rdata(rdata),
    .rd_en(rd_en), .out_valid(out_valid), .out_first(out_first),
    .out_data(out_data)
  );

  p_onehot_clr_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_v));
  p_trail_after_lead_r6: assert property (@(posedge clk) disable iff (rst)
    (push_v && push_word[TW+1]) |-> $past(push_v && !push_word[TW+1]));
  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(push_v && fifo_full));
endmodule

// File: tb/tot_sparsifier_tb_top.sv
module tot_sparsifier_tb_top;
  localparam int NCH = 8;
  localparam int TW  = 8;
  localparam int DEP = 8;
  localparam int SW  = 2;
  localparam int PW  = 16;
  localparam int NSTIM = 22;
  localparam int NEXP  = 14;

  // {lo[7:0], hi[7:0]} per sample
  localparam logic [15:0] STIM [NSTIM] = '{
    16'h0000, 16'h5C00, 16'h5C08, 16'h1C00, 16'h0000, 16'hC180,
    16'hC100, 16'h0000, 16'h0100, 16'h0101, 16'h0100, 16'h0100,
    16'h0100, 16'h0100, 16'h0100, 16'h0100, 16'h0100, 16'h0000,
    16'h0101, 16'h0100, 16'h0000, 16'h0000};

  // {chan, trailing, timeout, time}
  localparam logic [12:0] EXP [NEXP] = '{
    {3'd2, 1'b0, 1'b0, 8'd1}, {3'd2, 1'b1, 1'b0, 8'd4},
    {3'd3, 1'b0, 1'b0, 8'd1}, {3'd3, 1'b1, 1'b0, 8'd4},
    {3'd4, 1'b0, 1'b0, 8'd1}, {3'd4, 1'b1, 1'b0, 8'd4},
    {3'd6, 1'b0, 1'b0, 8'd5}, {3'd6, 1'b1, 1'b0, 8'd7},
    {3'd7, 1'b0, 1'b0, 8'd5}, {3'd7, 1'b1, 1'b0, 8'd7},
    {3'd0, 1'b0, 1'b0, 8'd8}, {3'd0, 1'b1, 1'b1, 8'd14},
    {3'd0, 1'b0, 1'b0, 8'd18}, {3'd0, 1'b1, 1'b0, 8'd20}};

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] lo_cmp = '0, hi_cmp = '0;
  logic [TW-1:0]  max_tot = 8'd6;
  logic           ovf_clr = 1'b0;
  logic           out_valid, out_first, overflow;
  logic [SW-1:0]  out_data;

  int checks = 0, errors = 0;
  int rx_n = 0, slot = 0, base = 0;
  logic [PW-1:0] rx [256];
  logic [PW-1:0] acc = '0;

  always #5 clk = ~clk;

  tot_sparsifier #(.NCH(NCH), .TW(TW), .FIFO_DEPTH(DEP)) dut_i (
    .clk(clk), .rst(rst), .lo_cmp(lo_cmp), .hi_cmp(hi_cmp),
    .max_tot(max_tot), .ovf_clr(ovf_clr), .out_valid(out_valid),
    .out_first(out_first), .out_data(out_data), .overflow(overflow));

  // slice collector (R7)
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (out_first) begin
        if (slot != 0) begin
          errors++;
          $display("FAIL R7 frame restarted at slice %0d (expected 8)", slot);
        end
        slot = 0;
        acc  = '0;
      end
      acc[slot*SW +: SW] = out_data;
      slot++;
      if (slot == 8) begin
        if (rx_n < 256) rx[rx_n] = acc;
        rx_n++;
        slot = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sample(input logic [NCH-1:0] lo, input logic [NCH-1:0] hi);
    lo_cmp = lo;
    hi_cmp = hi;
    repeat (8) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    lo_cmp = '0;
    hi_cmp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic string tag(input int i);
    case (i)
      0: return "R1";
      1: return "R2";
      2, 3, 4, 5: return "R3";
      6, 7, 8, 9: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R9: reset state
    chk(out_valid == 1'b0, "R9", "out_valid after reset", 32'(out_valid), 0);
    chk(overflow == 1'b0, "R9", "overflow after reset", 32'(overflow), 0);

    base = rx_n;
    for (int k = 0; k < NSTIM; k++) sample(STIM[k][15:8], STIM[k][7:0]);
    repeat (200) @(negedge clk);

    // R6 and R7: word count, order and layout
    chk(rx_n - base == NEXP, "R6", "word count", 32'(rx_n - base), NEXP);
    for (int i = 0; i < NEXP; i++) begin
      if (base + i < rx_n)
        chk(rx[base+i] == PW'(EXP[i]), tag(i), $sformatf("R7 word %0d", i),
            32'(rx[base+i]), 32'(EXP[i]));
    end
    chk(overflow == 1'b0, "R8", "no overflow in light traffic", 32'(overflow), 0);

    // R8: burst on every channel overfills the FIFO
    do_reset();
    max_tot = 8'd200;
    base = rx_n;
    sample('1, '1);
    sample('0, '0);
    repeat (300) @(negedge clk);
    chk(overflow == 1'b1, "R8", "overflow sticky after burst", 32'(overflow), 1);
    chk((rx_n - base >= DEP) && (rx_n - base < 2 * NCH), "R8",
        "words kept in burst", 32'(rx_n - base), DEP);
    if (rx_n > base)
      chk(rx[base] == PW'({3'd0, 1'b0, 1'b0, 8'd0}), "R6",
          "lowest channel drains first", 32'(rx[base]), 0);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    @(negedge clk);
    chk(overflow == 1'b0, "R8", "overflow cleared", 32'(overflow), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule